// File: doc/BRIEF.md
# Divided Countdown Timer

This block is a per-processor 32-bit countdown timer with a programmable power-of-two prescaler. Software loads a start value, picks a divide ratio and sets up a control word holding an 8-bit interrupt vector, a mask flag and a periodic flag. From the moment the start value is written, the current count drops by one on every divided tick. When it reaches zero the block emits a single-cycle request that carries the vector.

In one-shot mode the count then stays at zero. In periodic mode the next divided tick reloads the start value, so one period spans start+1 ticks. The divide ratio comes from a 3-bit code spread over bits 0, 1 and 3 of the divide register. Routing the request into any priority logic is left to the surrounding design.

Top module: `countdown_timer`

## Requirements
- R1: After reset every register reads 0, the current count reads 0 and no request is raised.
- R2: The divide register (address 2) keeps only write-data bits 0, 1 and 3, so a write of 0xFF reads back as 0xB.
- R3: The divide code is {bit3, bit1, bit0}. The prescale shift is (code+1) mod 8 and each divided tick spans 2^shift clocks, so code 7 counts every clock and code 6 every 128 clocks.
- R4: A write to the start value (address 0) loads the current count with that value and restarts the prescaler. With divide ratio D, the first decrement lands D clocks after the write edge.
- R5: In one-shot mode (control bit 17 clear) the count saturates at 0. The request is high for exactly one clock, N*D clocks after the write edge of start value N.
- R6: In periodic mode (control bit 17 set) a count of 0 reloads the start value on the next divided tick. Requests repeat every (N+1)*D clocks.
- R7: With the mask flag (control bit 16) set, no request is raised, but the count keeps running.
- R8: During a request, irq_vector equals control bits [7:0]. At all other times it is 0.
- R9: A start value of 0 leaves the timer stopped: the count stays 0 and no request is raised in either mode.
- R10: Writes to the current-count address (address 1) have no effect.
- R11: The control word is re-evaluated on every write. A one-shot timer resting at 0 that is switched to periodic reloads on the next divided tick.
- R12: Rewriting the start value while counting discards the old count and restarts from the new value.
- R13: The request output is never high on two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 start value, 1 current count (read only), 2 divide, 3 control |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address, same map as wr_addr |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| irq_pulse | output | 1 | One-clock timer request |
| irq_vector | output | 8 | Vector carried by the request, 0 when idle |

## Verification
The one-shot countdown is swept through all eight divide codes. Each clock's count and request are compared with values computed from elapsed divided ticks, which separates every ratio from its neighbours and exposes any off-by-one in the prescaler restart. Periodic runs at several ratios confirm the start+1 period and the repeated requests. A masked run shows that counting goes on while requests stay silent. Directed sequences cover a zero start value, writes to the read-only count, a switch from one-shot to periodic at rest, and a reload in the middle of a countdown. Each of these checks that the count goes where the requirement says and nowhere else.

// File: rtl/ctmr_pkg.sv
// Package: shared constants and the divide-code decode for the countdown timer.
// Assumes a 2-bit register address space and a 3-bit prescale shift.
package ctmr_pkg;
    localparam int ADDR_W   = 2;
    localparam int SHIFT_W  = 3;
    localparam int DIV_W    = 4;
    localparam int MASK_BIT = 16;
    localparam int PER_BIT  = 17;

    localparam logic [ADDR_W-1:0] A_START = 2'd0;
    localparam logic [ADDR_W-1:0] A_COUNT = 2'd1;
    localparam logic [ADDR_W-1:0] A_DIV   = 2'd2;
    localparam logic [ADDR_W-1:0] A_CTRL  = 2'd3;

    // Only bits 0, 1 and 3 of the divide register are kept.
    localparam logic [DIV_W-1:0] DIV_KEEP = 4'b1011;

    // Map the kept divide bits to a prescale shift: code = {b3,b1,b0}, shift = code+1 mod 8.
    function automatic logic [SHIFT_W-1:0] div_to_shift(input logic [DIV_W-1:0] cfg);
        logic [SHIFT_W-1:0] code;
        code = {cfg[3], cfg[1:0]};
        return code + SHIFT_W'(1);
    endfunction
endpackage

// File: rtl/ctmr_prescaler.sv
// Module: power-of-two prescaler. Emits one tick every 2^shift clocks.
// Assumes shift is stable except across a restart, which clears the phase.
module ctmr_prescaler #(
    parameter int SHIFT_W = 3,
    localparam int PRE_W  = (1 << SHIFT_W) - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               restart,
    input  logic [SHIFT_W-1:0] shift,
    output logic               tick
);
    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] limit;
    logic             at_limit;

    // Last phase value for the selected ratio.
    always_comb begin
        limit    = PRE_W'((PRE_W+1)'(1) << shift) - PRE_W'(1);
        at_limit = (cnt == limit);
        tick     = at_limit && !restart;
    end

    // Phase counter: clears on restart or at the end of a divided period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart || at_limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PRE_W'(1);
        end
    end

    // R3: between ticks and restarts the phase advances by exactly one.
    a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !tick) |=> (cnt == $past(cnt) + PRE_W'(1)));

    // R4: a restart always leaves the phase at zero.
    a_r4_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/ctmr_counter.sv
// Module: the countdown core. Holds the start value and the current count,
// and fires a one-clock request when the count reaches zero.
// Assumes one tick per divided period; a load takes priority over a tick.
module ctmr_counter #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    input  logic             mask,
    input  logic [VEC_W-1:0] vector,
    output logic [CNT_W-1:0] start_q,
    output logic [CNT_W-1:0] cur_q,
    output logic             fire_q,
    output logic [VEC_W-1:0] fire_vec_q
);
    logic active;

    // Running: a nonzero start value and either reloading or not yet at zero.
    always_comb begin
        active = (start_q != '0) && (periodic || (cur_q != '0));
    end

    // Count update, reload and request generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= '0;
            cur_q      <= '0;
            fire_q     <= 1'b0;
            fire_vec_q <= '0;
        end else begin
            fire_q     <= 1'b0;
            fire_vec_q <= '0;
            if (load) begin
                start_q <= load_val;
                cur_q   <= load_val;
            end else if (tick && active) begin
                if (cur_q == '0) begin
                    cur_q <= start_q;
                end else begin
                    cur_q <= cur_q - CNT_W'(1);
                    if ((cur_q == CNT_W'(1)) && !mask) begin
                        fire_q     <= 1'b1;
                        fire_vec_q <= vector;
                    end
                end
            end
        end
    end

    // R13: a request never lasts longer than one clock.
    a_r13_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |=> !fire_q);

    // R5: a request is only seen while the count sits at zero.
    a_r5_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
        fire_q |-> (cur_q == '0));

    // R5: in one-shot mode a zero count stays at zero unless reloaded.
    a_r5_oneshot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q == '0 && !periodic && !load) |=> (cur_q == '0));

    // R9: loading zero leaves the timer idle with no request.
    a_r9_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (load && load_val == '0) |=> (!fire_q && cur_q == '0));
endmodule

// File: rtl/countdown_timer.sv
// Module: top of the countdown timer. Decodes register writes and reads,
// keeps the divide and control registers, and joins prescaler and counter.
// Assumes single-cycle writes; reads are combinational.
module countdown_timer #(
    parameter int CNT_W = 32,
    parameter int VEC_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ctmr_pkg::ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]         wr_data,
    input  logic [ctmr_pkg::ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]         rd_data,
    output logic                     irq_pulse,
    output logic [VEC_W-1:0]         irq_vector
);
    import ctmr_pkg::*;

    logic [DIV_W-1:0]   div_q;
    logic [VEC_W-1:0]   vec_q;
    logic               mask_q;
    logic               per_q;
    logic               wr_start;
    logic               wr_div;
    logic               wr_ctrl;
    logic               tick;
    logic [SHIFT_W-1:0] shift;
    logic [CNT_W-1:0]   start_q;
    logic [CNT_W-1:0]   cur_q;

    // Write decode per register.
    always_comb begin
        wr_start = wr_en && (wr_addr == A_START);
        wr_div   = wr_en && (wr_addr == A_DIV);
        wr_ctrl  = wr_en && (wr_addr == A_CTRL);
        shift    = div_to_shift(div_q);
    end

    // Divide and control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            vec_q  <= '0;
            mask_q <= 1'b0;
            per_q  <= 1'b0;
        end else begin
            if (wr_div) begin
                div_q <= wr_data[DIV_W-1:0] & DIV_KEEP;
            end
            if (wr_ctrl) begin
                vec_q  <= wr_data[VEC_W-1:0];
                mask_q <= wr_data[MASK_BIT];
                per_q  <= wr_data[PER_BIT];
            end
        end
    end

    ctmr_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wr_start || wr_div),
        .shift   (shift),
        .tick    (tick)
    );

    ctmr_counter #(.CNT_W(CNT_W), .VEC_W(VEC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (wr_start),
        .load_val   (wr_data),
        .tick       (tick),
        .periodic   (per_q),
        .mask       (mask_q),
        .vector     (vec_q),
        .start_q    (start_q),
        .cur_q      (cur_q),
        .fire_q     (irq_pulse),
        .fire_vec_q (irq_vector)
    );

    // Read multiplexer.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_START: rd_data = start_q;
            A_COUNT: rd_data = cur_q;
            A_DIV:   rd_data[DIV_W-1:0] = div_q;
            default: begin
                rd_data[VEC_W-1:0] = vec_q;
                rd_data[MASK_BIT]  = mask_q;
                rd_data[PER_BIT]   = per_q;
            end
        endcase
    end

    // R10: a write to the count address alone never changes the start value.
    a_r10_count_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_COUNT) |=> (start_q == $past(start_q)));

    // R8: the vector is nonzero only while a request is raised.
    a_r8_vec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_pulse |-> (irq_vector == '0));
endmodule

// File: tb/sim_countdown_timer.sv
module sim_countdown_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;
    logic [7:0]  irq_vector;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    countdown_timer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .irq_pulse(irq_pulse), .irq_vector(irq_vector)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input int data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'(addr); wr_data = 32'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int ctrl(input bit per, input bit msk, input int vec);
        return (int'(per) << 17) | (int'(msk) << 16) | (vec & 255);
    endfunction

    function automatic int div_word(input int code);
        return ((code >> 2) & 1) << 3 | (code & 3);
    endfunction

    // Follow a run for ncyc clocks after the start-value write and compare each clock.
    task automatic follow(input string req, input int n, input int d, input bit per,
                          input bit msk, input int vec, input int ncyc);
        rd_addr = 2'd1;
        for (int c = 1; c <= ncyc; c++) begin
            int m, ecur, epul;
            @(negedge clk);
            m = c / d;
            if (n == 0) ecur = 0;
            else if (per) ecur = n - (m % (n + 1));
            else ecur = (m >= n) ? 0 : n - m;
            epul = 0;
            if (n != 0 && !msk && (c % d) == 0 && m > 0) begin
                if (per) epul = ((m % (n + 1)) == n) ? 1 : 0;
                else epul = (m == n) ? 1 : 0;
            end
            check({req, " count"}, int'(rd_data), ecur);
            check({req, " pulse"}, int'(irq_pulse), epul);
            check({req, " R8 vector"}, int'(irq_vector), epul ? vec : 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #1 check("R1 reset reg", int'(rd_data), 0);
        end
        check("R1 reset pulse", int'(irq_pulse), 0);

        // R2: divide keeps bits 0,1,3
        wr(2, 'hFF);
        rd_addr = 2'd2;
        #1 check("R2 divide mask", int'(rd_data), 'hB);

        // R3 R4 R5: one-shot sweep over all codes
        for (int code = 0; code < 8; code++) begin
            int d;
            d = 1 << ((code + 1) % 8);
            wr(2, div_word(code));
            wr(3, ctrl(0, 0, 'h40 + code));
            wr(0, 3);
            follow("R3 R4 R5 oneshot", 3, d, 0, 0, 'h40 + code, 3 * d + 2 * d + 2);
        end

        // R6: periodic at several ratios
        for (int code = 7; code < 10; code++) begin
            int d, cc;
            cc = code % 8;
            d = 1 << ((cc + 1) % 8);
            wr(2, div_word(cc));
            wr(3, ctrl(1, 0, 'hA5));
            wr(0, 2);
            follow("R6 periodic", 2, d, 1, 0, 'hA5, 3 * 3 * d + 1);
        end

        // R7: masked periodic, counting continues without requests
        wr(2, div_word(7));
        wr(3, ctrl(1, 1, 'h11));
        wr(0, 1);
        follow("R7 masked", 1, 1, 1, 1, 'h11, 8);

        // R9: zero start value in periodic mode
        wr(3, ctrl(1, 0, 'h22));
        wr(0, 0);
        follow("R9 zero start", 0, 1, 1, 0, 'h22, 12);

        // R10: write to count address while stopped at zero
        wr(3, ctrl(0, 0, 'h33));
        wr(0, 2);
        follow("R10 setup", 2, 1, 0, 0, 'h33, 4);
        wr(1, 77);
        rd_addr = 2'd1;
        #1 check("R10 count unchanged", int'(rd_data), 0);
        rd_addr = 2'd0;
        #1 check("R10 start unchanged", int'(rd_data), 2);
        check("R10 no pulse", int'(irq_pulse), 0);

        // R11: switch to periodic while resting at zero
        wr(3, ctrl(1, 0, 'h33));
        rd_addr = 2'd1;
        #1 check("R11 still zero at switch", int'(rd_data), 0);
        @(negedge clk);
        check("R11 reload", int'(rd_data), 2);
        @(negedge clk);
        check("R11 count 1", int'(rd_data), 1);
        @(negedge clk);
        check("R11 count 0", int'(rd_data), 0);
        check("R11 pulse", int'(irq_pulse), 1);
        check("R11 vector", int'(irq_vector), 'h33);

        // R12: rewrite start value mid-count
        wr(3, ctrl(0, 0, 'h5C));
        wr(0, 5);
        rd_addr = 2'd1;
        @(negedge clk);
        @(negedge clk);
        check("R12 mid count", int'(rd_data), 3);
        wr(0, 4);
        follow("R12 restart", 4, 1, 0, 0, 'h5C, 7);

        // R13: back-to-back periodic requests at ratio 1 never merge
        wr(3, ctrl(1, 0, 'h7E));
        wr(0, 1);
        begin
            int prev;
            prev = 0;
            for (int c = 0; c < 10; c++) begin
                @(negedge clk);
                check("R13 no double pulse", int'(prev && irq_pulse), 0);
                prev = int'(irq_pulse);
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule